// File: doc/BRIEF.md
# Ten-bit serializer with internal loopback

This block takes a 10-bit word that arrives already line-coded and sends it out one bit at a time. The word is registered on the rising edge of a word clock. A bit clock, supplied separately at exactly ten times the word rate and phase-aligned so that every tenth bit-clock rising edge coincides with a word-clock rising edge, shifts the word out. The least significant bit goes first. Consecutive words follow each other with no idle bit between them. The block does no coding of its own: the bits of the word appear on the wire unchanged.

A loopback enable, sampled on every bit-clock edge, chooses where each serial bit goes. When it is low, the stream drives the line output and the loopback output is held at 0. When it is high, the stream drives the loopback output, which feeds an internal receiver, and the line output is held at a static 0. A small bit-clock state machine has two states. `ST_IDLE` means no word is in flight. `ST_SEND` means a word is being shifted. Its transitions are:
- **start**: `ST_IDLE` to `ST_SEND`, when a freshly captured word is seen.
- **reload**: `ST_SEND` to `ST_SEND`, when the tenth bit goes out and a new word is waiting.
- **drain**: `ST_SEND` to `ST_IDLE`, when the tenth bit goes out and no new word has been captured.

Top module: `ser_tx_loop`

## Requirements
- R1: `tx_word` is sampled only at a word-clock rising edge; changes to it between those edges do not alter the transmitted bits.
- R2: Each captured word occupies exactly ten consecutive bit periods, and the next word's first bit follows the previous word's tenth bit with no gap.
- R3: Bits are sent in order bit 0, bit 1, … bit 9 of the captured word, unchanged, one per bit-clock edge.
- R4: While `lpbk_en` is 1 at a bit-clock edge, `ser_loop` carries the serial bit from that edge, and `ser_line` and `ser_loop` are never both 1.
- R5: While `lpbk_en` is 1 at a bit-clock edge, `ser_line` is 0 after that edge.
- R6: While `lpbk_en` is 0 at a bit-clock edge, `ser_line` carries the serial bit and `ser_loop` is 0 after that edge.
- R7: Bit 0 of a word appears after the first bit-clock rising edge following its capture edge, so the latency is one bit clock, and bit k appears after edge k+1.
- R8: During reset, and after reset until the first word is captured, both outputs are 0 and the state machine is in `ST_IDLE`.
- R9: If no new word has been captured by the time the tenth bit is sent, the machine takes the drain transition and both outputs stay 0 until a word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_clk | input | 1 | Word clock; `tx_word` is captured on its rising edge |
| bit_clk | input | 1 | Bit clock at ten times the word rate, aligned with `word_clk` |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| tx_word | input | 10 | Pre-coded parallel word to transmit |
| lpbk_en | input | 1 | 1 steers the stream to `ser_loop`; 0 steers it to `ser_line` |
| ser_line | output | 1 | Serial line output, held at 0 during loopback |
| ser_loop | output | 1 | Serial stream to the internal receiver, 0 when loopback is off |

## Verification
The hardest case to reach from the ports is the drain transition. With a free-running word clock a new word is always waiting at the tenth bit, so `ST_SEND` never leaves itself. The bench therefore gates the word clock off for several word periods and later restarts it. It then checks that the outputs fall to 0 after the last bit and that the restart goes through the start transition with the same one-bit latency. Loopback is also toggled at offsets that fall inside words, so that a single word is split between the two outputs.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Sequencer states of the bit-clock state machine.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

endpackage

// File: rtl/sertx_word_cap.sv
// Word-clock domain: holds the captured word and flips a marker bit on
// every capture so the bit-clock side can see that a new word exists.
module sertx_word_cap #(
    parameter int WORD_W = 10
) (
    input  logic              word_clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] word_q,
    output logic              mark_q
);

    always_ff @(posedge word_clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            mark_q <= 1'b0;
        end else begin
            word_q <= tx_word;
            mark_q <= ~mark_q;
        end
    end

endmodule

// File: rtl/sertx_seq.sv
// Bit-clock domain sequencer: loads a word the edge after capture, then
// shifts it out least significant bit first for WORD_W bit periods.
module sertx_seq
    import sertx_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              mark_in,
    output tx_state_e         st,
    output logic [CNT_W-1:0]  cnt,
    output logic              bit_nxt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    tx_state_e         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [WORD_W-1:0] sh_q, sh_d;
    logic              seen_q, seen_d;
    logic              fresh;
    logic              load;

    assign fresh = (mark_in != seen_q);

    // Next-state process.
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        sh_d   = sh_q;
        seen_d = seen_q;
        load   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (fresh) begin
                    load = 1'b1;          // start
                    st_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (cnt_q == LAST) begin
                    if (fresh) begin
                        load = 1'b1;      // reload
                    end else begin
                        st_d = ST_IDLE;   // drain
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (load) begin
            cnt_d  = '0;
            sh_d   = word_in >> 1;
            seen_d = mark_in;
        end else if (st_q == ST_SEND && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
            sh_d  = sh_q >> 1;
        end
    end

    // State register process.
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            sh_q   <= '0;
            seen_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            sh_q   <= sh_d;
            seen_q <= seen_d;
        end
    end

    // Output process: the bit that leaves on this edge.
    always_comb begin
        if (load) begin
            bit_nxt = word_in[0];
        end else if (st_q == ST_SEND && cnt_q != LAST) begin
            bit_nxt = sh_q[0];
        end else begin
            bit_nxt = 1'b0;
        end
    end

    assign st  = st_q;
    assign cnt = cnt_q;

endmodule

// File: rtl/sertx_steer.sv
// Registers the serial bit onto the line or loopback output.
module sertx_steer (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic lpbk_en,
    input  logic bit_nxt,
    output logic ser_line,
    output logic ser_loop
);

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_line <= 1'b0;
            ser_loop <= 1'b0;
        end else begin
            ser_line <= lpbk_en ? 1'b0 : bit_nxt;
            ser_loop <= lpbk_en ? bit_nxt : 1'b0;
        end
    end

endmodule

// File: rtl/ser_tx_loop.sv
module ser_tx_loop
    import sertx_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic              word_clk,
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              lpbk_en,
    output logic              ser_line,
    output logic              ser_loop
);

    logic [WORD_W-1:0] cap_word;
    logic              cap_mark;
    tx_state_e         fsm_st;
    logic [CNT_W-1:0]  fsm_cnt;
    logic              bit_nxt;

    sertx_word_cap #(.WORD_W(WORD_W)) u_cap (
        .word_clk (word_clk),
        .rst_n    (rst_n),
        .tx_word  (tx_word),
        .word_q   (cap_word),
        .mark_q   (cap_mark)
    );

    sertx_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .word_in  (cap_word),
        .mark_in  (cap_mark),
        .st       (fsm_st),
        .cnt      (fsm_cnt),
        .bit_nxt  (bit_nxt)
    );

    sertx_steer u_steer (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .lpbk_en  (lpbk_en),
        .bit_nxt  (bit_nxt),
        .ser_line (ser_line),
        .ser_loop (ser_loop)
    );

endmodule

// File: rtl/ser_tx_loop_chk.sv
module ser_tx_loop_chk
    import sertx_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input logic             bit_clk,
    input logic             rst_n,
    input logic             lpbk_en,
    input logic             ser_line,
    input logic             ser_loop,
    input tx_state_e        st,
    input logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    // R5: line is quiet after an edge that saw loopback on
    a_r5_line_static: assert property (@(posedge bit_clk) disable iff (!rst_n)
        lpbk_en |=> (ser_line == 1'b0));

    // R6: loopback output is quiet after an edge that saw loopback off
    a_r6_loop_quiet: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !lpbk_en |=> (ser_loop == 1'b0));

    // R4: the stream never appears on both outputs
    a_r4_one_path: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $onehot0({ser_line, ser_loop}));

    // R2: inside a word the bit counter steps by one each edge
    a_r2_count_step: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (st == ST_SEND && cnt != LAST) |=> (st == ST_SEND && cnt == $past(cnt) + 1'b1));

    // R8 / R9: no word in flight means both outputs are low
    a_r9_idle_quiet: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (ser_line == 1'b0 && ser_loop == 1'b0));

endmodule

bind ser_tx_loop ser_tx_loop_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .lpbk_en  (lpbk_en),
    .ser_line (ser_line),
    .ser_loop (ser_loop),
    .st       (fsm_st),
    .cnt      (fsm_cnt)
);

// File: tb/ser_tx_loop_bench.sv
`timescale 1ns/100ps
module ser_tx_loop_bench;

    logic       word_clk = 1'b0;
    logic       bit_clk  = 1'b0;
    logic       rst_n    = 1'b0;
    logic [9:0] tx_word  = 10'h000;
    logic       lpbk_en  = 1'b0;
    logic       run      = 1'b0;
    logic       scr      = 1'b0;
    logic       ser_line;
    logic       ser_loop;

    int total = 0;
    int bad   = 0;

    ser_tx_loop u_ser_tx_loop (
        .word_clk (word_clk),
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .tx_word  (tx_word),
        .lpbk_en  (lpbk_en),
        .ser_line (ser_line),
        .ser_loop (ser_loop)
    );

    // 125 MHz word clock (gated by run), bit clock ten times faster, edges aligned.
    initial begin
        #0.4;
        forever begin
            word_clk = run;
            #4;
            word_clk = 1'b0;
            #4;
        end
    end
    initial begin
        forever begin
            #0.4 bit_clk = ~bit_clk;
        end
    end

    // Behavioural reference model, evaluated on each bit-clock edge.
    int         n_edge = 0;
    int         ph;
    logic [9:0] m_cap = '0;
    bit         m_cap_v = 0;
    logic [9:0] m_cur = '0;
    int         m_idx = 0;
    bit         m_act = 0;
    bit         m_any = 0;
    bit         m_lp = 0;
    bit         m_started = 0;
    logic       e_line = 0;
    logic       e_loop = 0;

    always @(posedge bit_clk) begin
        logic b;
        ph = n_edge % 10;
        n_edge++;
        m_started = 1;
        if (!rst_n) begin
            m_cap_v = 0; m_act = 0; m_any = 0;
            e_line = 0;  e_loop = 0;
        end else begin
            if (ph == 1) begin
                if (m_cap_v) begin
                    m_cur = m_cap; m_idx = 0; m_act = 1; m_cap_v = 0; m_any = 1;
                end else begin
                    m_act = 0;
                end
            end else if (m_act) begin
                m_idx++;
                if (m_idx > 9) m_act = 0;
            end
            b = m_act ? m_cur[m_idx] : 1'b0;
            m_lp = lpbk_en;
            e_line = m_lp ? 1'b0 : b;
            e_loop = m_lp ? b : 1'b0;
            if (ph == 0 && run) begin
                m_cap = tx_word; m_cap_v = 1;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge bit_clk) begin
        string tl, tp;
        if (m_started) begin
            if (!m_any)                     tl = "R8 reset/idle line";
            else if (m_lp)                  tl = "R5 line static in loopback";
            else if (!m_act)                tl = "R9 drained line";
            else if (m_idx == 0)            tl = "R7 first-bit latency";
            else if (m_idx == 9)            tl = "R2 word boundary";
            else if (scr)                   tl = "R1 capture edge only";
            else                            tl = "R3 bit order";
            if (!m_any)                     tp = "R8 reset/idle loop";
            else if (m_lp)                  tp = "R4 loopback stream";
            else                            tp = "R6 loop quiet";
            chk(tl, ser_line, e_line);
            chk(tp, ser_loop, e_loop);
        end
    end

    // Word source: junk mid-period when scrambling, real word before the capture edge.
    int wk = 0;
    function automatic logic [9:0] pat(input int k);
        case (k)
            0: pat = 10'b0101111100;
            1: pat = 10'b1010000011;
            2: pat = 10'h3FF;
            3: pat = 10'h000;
            4: pat = 10'h001;
            5: pat = 10'h200;
            6: pat = 10'h155;
            7: pat = 10'h2AA;
            default: pat = 10'((k * 693) ^ (k << 3));
        endcase
    endfunction

    always @(negedge bit_clk) begin
        int nph;
        nph = n_edge % 10;
        if (scr && nph == 3) tx_word = ~pat(wk + 17);
        if (nph == 7) begin
            tx_word = pat(wk);
            wk++;
        end
    end

    initial begin
        repeat (20) @(negedge bit_clk);
        rst_n = 1'b1;                       // R8: word clock still gated
        repeat (30) @(negedge bit_clk);
        run = 1'b1;                         // R3 / R7 / R2
        repeat (120) @(negedge bit_clk);
        scr = 1'b1;                         // R1
        repeat (120) @(negedge bit_clk);
        scr = 1'b0;
        lpbk_en = 1'b1;                     // R4 / R5
        repeat (100) @(negedge bit_clk);
        for (int i = 0; i < 10; i++) begin  // loopback flips inside words
            repeat (7) @(negedge bit_clk);
            lpbk_en = ~lpbk_en;
        end
        lpbk_en = 1'b0;
        repeat (40) @(negedge bit_clk);
        run = 1'b0;                         // R9: drain to idle
        repeat (33) @(negedge bit_clk);
        run = 1'b1;                         // restart via start transition
        repeat (200) @(negedge bit_clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 0.8);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule